// File: doc/BRIEF.md
# Two-Line Gray-Stepped SRAM Access Sequencer

This block lets a microcontroller reach a byte-wide parallel SRAM through two control lines and one 8-bit data path. The two lines carry a 2-bit step code. The microcontroller places a byte on the shared data path and then moves the code forward one step. The block first takes the upper part of the address. It then takes the lower part of the address and a read/write flag from the same byte. On the last step it performs the access by pulsing the SRAM strobes. The address bytes and the data move over the same lines, one after another, in the way a multiplexed address/data bus works with an address-latch pulse.

The step codes follow a Gray order, so each legal step changes only one control line. The control lines are asynchronous to the block clock. They pass through a two-flop synchronizer and must then hold one more clock before a code is accepted. A code change that does not follow the forward sequence aborts the access: the sequencer returns to idle and both strobes are released. During a write, the block drives the SRAM data pins itself. During a read, it releases those pins, enables the SRAM output and returns the data to the microcontroller side.

Top module: `gray_bus_seq`

## Requirements
- R1: While reset is held and in the cycle after it, sram_we_n and sram_oe_n are 1, sram_d_oe and mcu_d_oe are 0, and sram_addr_o is 0.
- R2: The step codes on ctl_i are idle=00, upper=01, lower=11, execute=10. Stepping from idle to 01 copies the byte on mcu_d_i into sram_addr_o[14:7].
- R3: Stepping from 01 to 11 copies mcu_d_i[6:0] into sram_addr_o[6:0] and takes mcu_d_i[7] as the access kind (1 = write, 0 = read).
- R4: A code is acted on only after two synchronizer flops and one further clock in which it is unchanged. A code pulse that lasts one clock has no effect on any output.
- R5: In execute with the write flag, sram_we_n goes low for exactly WE_CYCLES clocks. During that time sram_d_oe is 1, sram_d_o carries the byte on mcu_d_i at execute entry, sram_addr_o is steady and sram_oe_n stays 1.
- R6: In execute with the read flag, sram_oe_n is low for the whole execute step. sram_d_oe is 0, mcu_d_oe is 1, and mcu_d_o returns the SRAM data (sram_d_i with a one-clock register delay).
- R7: Any accepted code other than the next step in the order idle, 01, 11, 10, idle sends the sequencer to idle. The aborted sequence produces no strobe pulse.
- R8: Leaving execute releases sram_we_n, sram_oe_n, sram_d_oe and mcu_d_oe on the clock after the code is accepted, which is the fifth rising edge after ctl_i changes. The address latches keep their values in idle.
- R9: sram_we_n and sram_oe_n are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_i | input | 2 | Asynchronous step code from the microcontroller |
| mcu_d_i | input | 8 | Byte the microcontroller drives on the shared path |
| mcu_d_o | output | 8 | Read data returned to the microcontroller |
| mcu_d_oe | output | 1 | Drive enable for mcu_d_o |
| sram_addr_o | output | 15 | Latched SRAM address |
| sram_d_i | input | 8 | Data from the SRAM pins |
| sram_d_o | output | 8 | Write data to the SRAM pins |
| sram_d_oe | output | 1 | Drive enable for sram_d_o |
| sram_we_n | output | 1 | Active-low SRAM write strobe |
| sram_oe_n | output | 1 | Active-low SRAM output enable |

## Verification
The assertions assume that the microcontroller changes the byte on mcu_d_i together with the step code and then holds both until the code has been accepted. This way, the captured byte always belongs to the step it arrives with. The stimulus holds every step for ten clocks, well past the five-clock acceptance delay. It changes bytes only at the same moment as a code change, except in the deliberate one-clock glitch. The aborted sequences move the code into illegal orders, including a two-line jump and backward steps, but always with the same hold time. Because of that, any strobe that shows up is an actual decode error and not an input that was sampled while still settling.

// File: rtl/gbs_pkg.sv
package gbs_pkg;

  // Gray-ordered step codes: each legal step flips a single line
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_UPR  = 2'b01,
    ST_LWR  = 2'b11,
    ST_EXE  = 2'b10
  } step_t;

  function automatic step_t step_after(step_t s);
    case (s)
      ST_IDLE: return ST_UPR;
      ST_UPR:  return ST_LWR;
      ST_LWR:  return ST_EXE;
      default: return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/gbs_sync.sv
module gbs_sync #(
  parameter int W      = 10,
  parameter int CW     = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] held_o,
  output logic         chg_o
);

  // pipe[0..STAGES-1] is the synchronizer, pipe[STAGES] the stability compare
  logic [STAGES:0][W-1:0] pipe;
  logic settled, fresh;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= async_i;
      for (int k = 1; k <= STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign settled = (pipe[STAGES] == pipe[STAGES-1]);
  assign fresh   = settled && (pipe[STAGES-1][CW-1:0] != held_o[CW-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_o <= '0;
      chg_o  <= 1'b0;
    end else begin
      chg_o <= fresh;
      if (fresh) held_o <= pipe[STAGES-1];
    end
  end

endmodule

// File: rtl/gbs_fsm.sv
module gbs_fsm
  import gbs_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chg_i,
  input  logic [1:0]        code_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_o,
  output logic              exe_enter_o,
  output logic              exe_leave_o
);

  step_t st, want;
  logic [DATA_W-1:0] upr_q;
  logic [DATA_W-2:0] lwr_q;
  logic fwd;

  assign want        = step_after(st);
  assign fwd         = chg_i && (step_t'(code_i) == want);
  assign exe_enter_o = fwd && (want == ST_EXE);
  assign exe_leave_o = chg_i && (st == ST_EXE);
  assign addr_o      = {upr_q, lwr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      upr_q <= '0;
      lwr_q <= '0;
      wr_o  <= 1'b0;
    end else if (chg_i) begin
      if (fwd) begin
        st <= want;
        if (want == ST_UPR) upr_q <= byte_i;
        if (want == ST_LWR) {wr_o, lwr_q} <= byte_i;
      end else begin
        st <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/gbs_strobe.sv
module gbs_strobe #(
  parameter int DATA_W    = 8,
  parameter int WE_CYCLES = 4,
  localparam int CNT_W    = $clog2(WE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter_i,
  input  logic              leave_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] sram_d_i,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_d_o,
  output logic              sram_d_oe,
  output logic [DATA_W-1:0] mcu_d_o,
  output logic              mcu_d_oe
);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_we_n <= 1'b1;
      sram_oe_n <= 1'b1;
      sram_d_o  <= '0;
      sram_d_oe <= 1'b0;
      mcu_d_o   <= '0;
      mcu_d_oe  <= 1'b0;
      left_q    <= '0;
    end else if (leave_i) begin
      sram_we_n <= 1'b1;
      sram_oe_n <= 1'b1;
      sram_d_oe <= 1'b0;
      mcu_d_oe  <= 1'b0;
      left_q    <= '0;
    end else if (enter_i) begin
      if (wr_i) begin
        sram_we_n <= 1'b0;
        sram_d_oe <= 1'b1;
        sram_d_o  <= wdata_i;
        left_q    <= CNT_W'(WE_CYCLES - 1);
      end else begin
        sram_oe_n <= 1'b0;
        mcu_d_oe  <= 1'b1;
      end
    end else begin
      if (!sram_we_n) begin
        if (left_q == '0) sram_we_n <= 1'b1;
        else              left_q    <= left_q - 1'b1;
      end
      if (!sram_oe_n) mcu_d_o <= sram_d_i;
    end
  end

endmodule

// File: rtl/gray_bus_seq.sv
module gray_bus_seq #(
  parameter int DATA_W      = 8,
  parameter int WE_CYCLES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          ctl_i,
  input  logic [DATA_W-1:0]   mcu_d_i,
  output logic [DATA_W-1:0]   mcu_d_o,
  output logic                mcu_d_oe,
  output logic [2*DATA_W-2:0] sram_addr_o,
  input  logic [DATA_W-1:0]   sram_d_i,
  output logic [DATA_W-1:0]   sram_d_o,
  output logic                sram_d_oe,
  output logic                sram_we_n,
  output logic                sram_oe_n
);

  localparam int BUS_W = DATA_W + 2;

  logic [BUS_W-1:0] held;
  logic chg, wr, enter, leave;

  gbs_sync #(.W(BUS_W), .CW(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i({mcu_d_i, ctl_i}),
    .held_o(held), .chg_o(chg)
  );

  gbs_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .chg_i(chg), .code_i(held[1:0]),
    .byte_i(held[BUS_W-1:2]), .addr_o(sram_addr_o), .wr_o(wr),
    .exe_enter_o(enter), .exe_leave_o(leave)
  );

  gbs_strobe #(.DATA_W(DATA_W), .WE_CYCLES(WE_CYCLES)) u_strobe (
    .clk(clk), .rst(rst), .enter_i(enter), .leave_i(leave), .wr_i(wr),
    .wdata_i(held[BUS_W-1:2]), .sram_d_i(sram_d_i),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_d_o(sram_d_o), .sram_d_oe(sram_d_oe),
    .mcu_d_o(mcu_d_o), .mcu_d_oe(mcu_d_oe)
  );

endmodule

// File: rtl/gbs_chk.sv
module gbs_chk #(
  parameter int DATA_W    = 8,
  parameter int WE_CYCLES = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [2*DATA_W-2:0] sram_addr_o,
  input logic                sram_we_n,
  input logic                sram_oe_n,
  input logic                sram_d_oe,
  input logic                mcu_d_oe
);

  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (rst) low_run <= '0;
    else     low_run <= sram_we_n ? 16'd0 : low_run + 16'd1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (sram_we_n && sram_oe_n && !sram_d_oe && !mcu_d_oe));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!sram_we_n && !sram_oe_n));

  // R5
  we_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> sram_d_oe);

  // R5
  we_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_addr_o));

  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    low_run <= 16'(WE_CYCLES));

  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> (!sram_d_oe && mcu_d_oe));

endmodule

bind gray_bus_seq gbs_chk #(.DATA_W(DATA_W), .WE_CYCLES(WE_CYCLES)) u_chk (.*);

// File: tb/tb_gray_bus_seq.sv
module tb_gray_bus_seq;
  localparam int DW = 8;
  localparam int AW = 2 * DW - 1;
  localparam int WEC = 4;
  localparam int HOLD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] ctl = 2'b00;
  logic [DW-1:0] bus = '0, sram_rd = '0;
  logic [DW-1:0] mcu_d_o, sram_d_o;
  logic [AW-1:0] sram_addr_o;
  logic mcu_d_oe, sram_d_oe, sram_we_n, sram_oe_n;

  always #5 clk = ~clk;

  gray_bus_seq #(.DATA_W(DW), .WE_CYCLES(WEC), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .ctl_i(ctl), .mcu_d_i(bus), .mcu_d_o(mcu_d_o),
    .mcu_d_oe(mcu_d_oe), .sram_addr_o(sram_addr_o), .sram_d_i(sram_rd),
    .sram_d_o(sram_d_o), .sram_d_oe(sram_d_oe), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n)
  );

  typedef struct { bit wr; logic [AW-1:0] addr; logic [DW-1:0] data; } item_t;
  item_t exp_q[$];
  logic [DW-1:0] ref_mem [int];
  logic [DW-1:0] mem [int];
  int n_cmp = 0, n_bad = 0;
  bit reported = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  // SRAM model; unwritten locations read as EE
  always @(posedge clk) begin
    if (!sram_we_n) mem[int'(sram_addr_o)] = sram_d_o;
    sram_rd <= mem.exists(int'(sram_addr_o)) ? mem[int'(sram_addr_o)] : 8'hEE;
  end

  task automatic pop_cmp(bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
    item_t it;
    if (exp_q.size() == 0) begin
      chk("R7", "strobe with nothing expected", 1, 0);
    end else begin
      it = exp_q.pop_front();
      chk(wr ? "R5" : "R6", "access kind", wr, it.wr);
      chk(wr ? "R5" : "R6", "access address", a, it.addr);
      chk(wr ? "R5" : "R6", "access data", d, it.data);
    end
  endtask

  // monitor: pops the scoreboard at the end of each strobe pulse
  int wlen = 0, olen = 0;
  logic [AW-1:0] wa, oa;
  logic [DW-1:0] wd, od;
  bit odir;
  always @(negedge clk) begin
    if (!rst) begin
      if (!sram_we_n && !sram_oe_n) chk("R9", "both strobes low", 1, 0);
      if (!sram_we_n) begin
        if (wlen == 0) begin wa = sram_addr_o; wd = sram_d_o; end
        wlen++;
      end else if (wlen > 0) begin
        pop_cmp(1'b1, wa, wd);
        chk("R5", "write strobe width", wlen, WEC);
        wlen = 0;
      end
      if (!sram_oe_n) begin
        oa = sram_addr_o; od = mcu_d_o; odir = mcu_d_oe && !sram_d_oe;
        olen++;
      end else if (olen > 0) begin
        pop_cmp(1'b0, oa, od);
        chk("R6", "read bus direction", odir, 1);
        olen = 0;
      end
    end
  end

  task automatic step(logic [1:0] c, logic [DW-1:0] b);
    @(negedge clk);
    bus = b; ctl = c;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic access(logic [AW-1:0] a, bit wr, logic [DW-1:0] d);
    item_t it;
    step(2'b01, a[AW-1:7]);
    chk("R2", "upper address latched", sram_addr_o[AW-1:7], a[AW-1:7]);
    step(2'b11, {wr, a[6:0]});
    chk("R3", "lower address latched", sram_addr_o, a);
    it.wr = wr; it.addr = a;
    if (wr) begin
      it.data = d;
      ref_mem[int'(a)] = d;
    end else begin
      it.data = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'hEE;
    end
    exp_q.push_back(it);
    step(2'b10, wr ? d : 8'h00);
    // leave execute: release lands on the fifth rising edge
    @(negedge clk);
    bus = 8'h00; ctl = 2'b00;
    repeat (4) @(posedge clk);
    #1;
    if (wr) chk("R8", "write drive still on before release", sram_d_oe, 1);
    else    chk("R8", "read enable still on before release", sram_oe_n, 0);
    @(posedge clk);
    #1;
    chk("R8", "strobes released", {sram_we_n, sram_oe_n, sram_d_oe, mcu_d_oe}, 4'b1100);
    repeat (HOLD) @(negedge clk);
    chk("R8", "address kept in idle", sram_addr_o, a);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    chk("R1", "strobes at reset", {sram_we_n, sram_oe_n}, 2'b11);
    chk("R1", "drive enables at reset", {sram_d_oe, mcu_d_oe}, 2'b00);
    chk("R1", "address at reset", sram_addr_o, 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    access(15'h0000, 1'b1, 8'hA5);
    access(15'h7FFF, 1'b1, 8'h3C);
    access(15'h2AB5, 1'b1, 8'h81);
    access(15'h0000, 1'b0, 8'h00);
    access(15'h2AB5, 1'b0, 8'h00);
    access(15'h7FFF, 1'b0, 8'h00);
    access(15'h0100, 1'b0, 8'h00);
    access(15'h7FFF, 1'b1, 8'hC3);
    access(15'h7FFF, 1'b0, 8'h00);

    // R4: one-clock pulse on the code lines
    @(negedge clk);
    bus = 8'h11; ctl = 2'b01;
    @(negedge clk);
    bus = 8'h00; ctl = 2'b00;
    repeat (HOLD) @(negedge clk);
    chk("R4", "glitch left address untouched", sram_addr_o, 15'h7FFF);

    // R7: two-line jump from idle, then execute code
    step(2'b11, 8'hFF);
    step(2'b10, 8'h77);
    step(2'b00, 8'h00);
    chk("R7", "jump caused no strobe", {sram_we_n, sram_oe_n}, 2'b11);
    chk("R7", "jump left latches", sram_addr_o, 15'h7FFF);

    // R7: backward step from lower back to upper, then execute code
    step(2'b01, 8'h12);
    step(2'b11, 8'h80);
    step(2'b01, 8'h12);
    step(2'b10, 8'h55);
    step(2'b00, 8'h00);
    chk("R7", "backward step caused no strobe", {sram_we_n, sram_oe_n}, 2'b11);

    // R7: lower straight to idle (two lines) then execute code
    step(2'b01, 8'h40);
    step(2'b11, 8'h81);
    step(2'b00, 8'h00);
    step(2'b10, 8'h66);
    step(2'b00, 8'h00);

    access(15'h1234, 1'b1, 8'h5A);
    access(15'h1234, 1'b0, 8'h00);

    repeat (HOLD) @(negedge clk);
    chk("R7", "scoreboard drained", exp_q.size(), 0);
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk("R1", "watchdog expired", 1, 0);
    report();
    $finish;
  end

endmodule